// File: doc/BRIEF.md
# Boot Remap Address Controller

This block sits beside a system bus decoder and owns the placement of two slaves: a boot ROM and a main RAM. Out of reset the ROM answers at address zero so the processor can fetch its first instructions there. Once software has brought the RAM up, it writes the remap bit of the control word. On the next clock edge the RAM window drops to address zero and the ROM moves to the address just past the end of the RAM. The new ROM base is derived from the RAM's encoded size.

A 32-bit word-addressed register port inside a 4 KiB window gives access to both slave configuration words, the control word and a constant identification word. Each configuration word carries a base in bits [31:20] (in MiB units) and attributes in bits [19:0]. Bits [19:16] of the attributes hold a size code k, meaning a window of 2^k MiB.

The current configuration words and the remapped flag are driven out to the decoder. A combinational hit test for each window is also provided. The remap happens once and is undone only by reset.

Top module: `bus_remap_ctrl`

## Requirements
- R1: After reset, `remapped` is 0, `rom_cfg` equals parameter ROM_RESET, `ram_cfg` equals parameter RAM_RESET, and the control word reads 0.
- R2: A read at byte offset 0x8C returns the identification constant 0x00010301.
- R3: A read at offset ROM_SLOT*4 (0x10 by default) returns `rom_cfg`, and a read at RAM_SLOT*4 (0x18) returns `ram_cfg`. Every other offset in the window except 0x88 and 0x8C reads 0, including 0x80 and 0x84.
- R4: A write at offset 0x88 stores all 32 bits of the control word, which read back from the next cycle on, whether or not the remap has happened.
- R5: A write at 0x88 with bit 0 set while `remapped` is 0 has the following effect one cycle later. `remapped` is 1. `rom_cfg` becomes (2^(20+k)) OR (old `rom_cfg` bits [19:0]), where k is `ram_cfg` bits [19:16] truncated to 32 bits. `ram_cfg` keeps only its bits [19:0], so its base becomes 0.
- R6: A control write with bit 0 clear leaves `remapped` and both configuration words unchanged.
- R7: Once `remapped` is 1, it stays 1 until reset, and later control writes (bit 0 set or clear) leave both configuration words unchanged.
- R8: Writes to any offset other than 0x88, including the two slave offsets, change neither configuration word nor the control word.
- R9: `rom_hit` (`ram_hit`) is 1 exactly when `dec_addr` bits [31:20] lie in [base, base + 2^k) of the current `rom_cfg` (`ram_cfg`). The result follows the new placement in the cycle after the triggering write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset (bits [1:0] ignored) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| dec_addr | input | 32 | Bus address to classify |
| rom_hit | output | 1 | `dec_addr` falls in the ROM window |
| ram_hit | output | 1 | `dec_addr` falls in the RAM window |
| rom_cfg | output | 32 | Current ROM base/attribute word |
| ram_cfg | output | 32 | Current RAM base/attribute word |
| remapped | output | 1 | Remap has taken place since reset |

## Verification
The bench builds the block with ROM_RESET = 0x00030000 (base 0, 8 MiB) and RAM_RESET = 0x10050000 (base 256 MiB, 32 MiB). The RAM size code 5 gives a nonzero rebased ROM base of 32 MiB, and the two windows are disjoint both before and after remap. With these values, the window edges on either side of each base and limit can be probed with a few addresses. The same values expose a missing attribute carry-over, a wrong shift offset, or a RAM base that fails to clear.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int unsigned CFG_W      = 32;
  localparam int unsigned BASE_LSB   = 20;
  localparam int unsigned SIZE_LSB   = 16;
  localparam int unsigned SIZE_W     = 4;
  localparam int unsigned BASE_W     = CFG_W - BASE_LSB;
  localparam logic [11:0] OFF_CTRL   = 12'h088;
  localparam logic [11:0] OFF_IDENT  = 12'h08C;

  typedef struct packed {
    logic [CFG_W-1:0] rom;
    logic [CFG_W-1:0] ram;
  } cfg_pair_t;

  // Relocation applied by the remap: RAM to zero, ROM to the end of RAM.
  function automatic cfg_pair_t relocate(input logic [CFG_W-1:0] rom_in,
                                         input logic [CFG_W-1:0] ram_in);
    cfg_pair_t        res;
    logic [SIZE_W-1:0] k;
    logic [5:0]        sh;
    k       = ram_in[SIZE_LSB +: SIZE_W];
    sh      = 6'(BASE_LSB) + {2'b00, k};
    res.rom = (CFG_W'(1) << sh) | {{BASE_W{1'b0}}, rom_in[BASE_LSB-1:0]};
    res.ram = {{BASE_W{1'b0}}, ram_in[BASE_LSB-1:0]};
    return res;
  endfunction
endpackage

// File: rtl/remap_rst_sync.sv
module remap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/remap_state.sv
module remap_state
  import remap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter logic [31:0] ROM_RESET = 32'h0003_0000,
  parameter logic [31:0] RAM_RESET = 32'h1005_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CFG_W-1:0]  wr_data,
  output logic [CFG_W-1:0]  ctrl_q,
  output logic [CFG_W-1:0]  rom_q,
  output logic [CFG_W-1:0]  ram_q,
  output logic              done_q
);
  localparam logic [ADDR_W-3:0] CTRL_WORD = OFF_CTRL[ADDR_W-1:2];

  logic             ctrl_en;
  logic             move_en;
  logic [CFG_W-1:0] ctrl_d;
  logic [CFG_W-1:0] rom_d;
  logic [CFG_W-1:0] ram_d;
  logic             done_d;
  cfg_pair_t        moved;

  // Next-state logic
  always_comb begin
    ctrl_en = wr_en && (wr_addr[ADDR_W-1:2] == CTRL_WORD);
    move_en = ctrl_en && wr_data[0] && !done_q;
    moved   = relocate(rom_q, ram_q);
    ctrl_d  = wr_data;
    rom_d   = moved.rom;
    ram_d   = moved.ram;
    done_d  = 1'b1;
  end

  // Registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_q  <= ROM_RESET;
      ram_q  <= RAM_RESET;
      done_q <= 1'b0;
    end else if (move_en) begin
      rom_q  <= rom_d;
      ram_q  <= ram_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/remap_read_mux.sv
module remap_read_mux
  import remap_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned ROM_SLOT = 4,
  parameter int unsigned RAM_SLOT = 6,
  parameter logic [31:0] REV_ID   = 32'h0001_0301
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CFG_W-1:0]  ctrl_q,
  input  logic [CFG_W-1:0]  rom_q,
  input  logic [CFG_W-1:0]  ram_q,
  output logic [CFG_W-1:0]  rd_data
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_ROM   = WORD_W'(ROM_SLOT);
  localparam logic [WORD_W-1:0] W_RAM   = WORD_W'(RAM_SLOT);
  localparam logic [WORD_W-1:0] W_CTRL  = OFF_CTRL[ADDR_W-1:2];
  localparam logic [WORD_W-1:0] W_IDENT = OFF_IDENT[ADDR_W-1:2];

  logic [WORD_W-1:0] word;

  always_comb begin
    word = rd_addr[ADDR_W-1:2];
    if      (word == W_ROM)   rd_data = rom_q;
    else if (word == W_RAM)   rd_data = ram_q;
    else if (word == W_CTRL)  rd_data = ctrl_q;
    else if (word == W_IDENT) rd_data = REV_ID;
    else                      rd_data = '0;
  end
endmodule

// File: rtl/remap_window_dec.sv
module remap_window_dec
  import remap_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  input  logic [CFG_W-1:0] addr,
  output logic             hit
);
  logic [BASE_W-1:0] base_mb;
  logic [BASE_W-1:0] addr_mb;
  logic [BASE_W-1:0] offs_mb;
  logic [SIZE_W-1:0] k;

  always_comb begin
    base_mb = cfg[CFG_W-1:BASE_LSB];
    addr_mb = addr[CFG_W-1:BASE_LSB];
    k       = cfg[SIZE_LSB +: SIZE_W];
    offs_mb = addr_mb - base_mb;
    hit     = (addr_mb >= base_mb) && ((offs_mb >> k) == '0);
  end
endmodule

// File: rtl/bus_remap_ctrl.sv
module bus_remap_ctrl
  import remap_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned ROM_SLOT    = 4,
  parameter int unsigned RAM_SLOT    = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] ROM_RESET   = 32'h0003_0000,
  parameter logic [31:0] RAM_RESET   = 32'h1005_0000,
  parameter logic [31:0] REV_ID      = 32'h0001_0301
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       dec_addr,
  output logic              rom_hit,
  output logic              ram_hit,
  output logic [31:0]       rom_cfg,
  output logic [31:0]       ram_cfg,
  output logic              remapped
);
  localparam int unsigned N_WIN = 2;

  logic              rst_q_n;
  logic [CFG_W-1:0]  ctrl_q;
  logic [CFG_W-1:0]  win_cfg [N_WIN];
  logic [N_WIN-1:0]  win_hit;

  remap_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  remap_state #(
    .ADDR_W    (ADDR_W),
    .ROM_RESET (ROM_RESET),
    .RAM_RESET (RAM_RESET)
  ) u_state (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (reg_we),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .ctrl_q  (ctrl_q),
    .rom_q   (rom_cfg),
    .ram_q   (ram_cfg),
    .done_q  (remapped)
  );

  remap_read_mux #(
    .ADDR_W   (ADDR_W),
    .ROM_SLOT (ROM_SLOT),
    .RAM_SLOT (RAM_SLOT),
    .REV_ID   (REV_ID)
  ) u_rd (
    .rd_addr (reg_addr),
    .ctrl_q  (ctrl_q),
    .rom_q   (rom_cfg),
    .ram_q   (ram_cfg),
    .rd_data (reg_rdata)
  );

  assign win_cfg[0] = rom_cfg;
  assign win_cfg[1] = ram_cfg;

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    remap_window_dec u_dec (
      .cfg  (win_cfg[g]),
      .addr (dec_addr),
      .hit  (win_hit[g])
    );
  end

  assign rom_hit = win_hit[0];
  assign ram_hit = win_hit[1];
endmodule

// File: rtl/remap_ctrl_chk.sv
module remap_ctrl_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter logic [31:0] REV_ID = 32'h0001_0301
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [31:0]       rom_cfg,
  input logic [31:0]       ram_cfg,
  input logic              remapped
);
  logic ctl_wr;
  logic fire;
  assign ctl_wr = reg_we && (reg_addr[ADDR_W-1:2] == remap_pkg::OFF_CTRL[ADDR_W-1:2]);
  assign fire   = ctl_wr && reg_wdata[0] && !remapped;

  // R5: a qualifying control write sets the flag next cycle
  p_trigger_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> remapped);

  // R5: the RAM base is zero when the flag rises
  p_ram_base_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(remapped) |-> (ram_cfg[31:20] == 12'h000));

  // R6: without a qualifying write the flag does not rise
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!remapped && !fire) |=> !remapped);

  // R7: the flag is sticky
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    remapped |=> remapped);

  // R8: configuration words only move on a qualifying write
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(rom_cfg) && $stable(ram_cfg)));

  // R2: identification word
  p_ident_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[ADDR_W-1:2] == remap_pkg::OFF_IDENT[ADDR_W-1:2]) |-> (reg_rdata == REV_ID));
endmodule

bind bus_remap_ctrl remap_ctrl_chk #(.ADDR_W(ADDR_W), .REV_ID(REV_ID)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .rom_cfg   (rom_cfg),
  .ram_cfg   (ram_cfg),
  .remapped  (remapped)
);

// File: tb/sim_bus_remap_ctrl.sv
module sim_bus_remap_ctrl;
  localparam int          CLK_PERIOD = 10;
  localparam int unsigned ADDR_W     = 12;
  localparam logic [31:0] ROM_RST    = 32'h0003_0000;
  localparam logic [31:0] RAM_RST    = 32'h1005_0000;
  localparam logic [31:0] IDENT      = 32'h0001_0301;
  localparam int unsigned K_RAM      = 5;
  localparam logic [31:0] ROM_MOVED  = (32'h1 << (20 + K_RAM)) | (ROM_RST & 32'h000F_FFFF);
  localparam logic [31:0] RAM_MOVED  = RAM_RST & 32'h000F_FFFF;

  typedef struct packed {
    logic [15:0] tag;
    logic        we;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{"R2", 1'b0, 12'h08C, 32'h0,         IDENT},
    '{"R3", 1'b0, 12'h010, 32'h0,         ROM_RST},
    '{"R3", 1'b0, 12'h018, 32'h0,         RAM_RST},
    '{"R3", 1'b0, 12'h080, 32'h0,         32'h0},
    '{"R3", 1'b0, 12'h084, 32'h0,         32'h0},
    '{"R3", 1'b0, 12'h014, 32'h0,         32'h0},
    '{"R3", 1'b0, 12'hFFC, 32'h0,         32'h0},
    '{"R8", 1'b1, 12'h010, 32'hFFFF_FFFF, ROM_RST},
    '{"R8", 1'b1, 12'h018, 32'h0,         RAM_RST},
    '{"R8", 1'b1, 12'h080, 32'h0000_1234, 32'h0},
    '{"R6", 1'b1, 12'h088, 32'h0000_0002, 32'h0000_0002},
    '{"R4", 1'b1, 12'h088, 32'hA5A5_0000, 32'hA5A5_0000}
  };

  logic              clk;
  logic              rst_n;
  logic              reg_we;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic [31:0]       dec_addr;
  logic              rom_hit;
  logic              ram_hit;
  logic [31:0]       rom_cfg;
  logic [31:0]       ram_cfg;
  logic              remapped;

  int n_chk;
  int n_bad;

  bus_remap_ctrl #(
    .ADDR_W    (ADDR_W),
    .ROM_RESET (ROM_RST),
    .RAM_RESET (RAM_RST),
    .REV_ID    (IDENT)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .dec_addr  (dec_addr),
    .rom_hit   (rom_hit),
    .ram_hit   (ram_hit),
    .rom_cfg   (rom_cfg),
    .ram_cfg   (ram_cfg),
    .remapped  (remapped)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic dec_chk(input string req, input logic [31:0] a, input logic er, input logic em);
    dec_addr = a;
    #1;
    chk(req, {31'b0, rom_hit}, {31'b0, er});
    chk(req, {31'b0, ram_hit}, {31'b0, em});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic reset_state_chk();
    chk("R1", {31'b0, remapped}, 32'h0);
    chk("R1", rom_cfg, ROM_RST);
    chk("R1", ram_cfg, RAM_RST);
    rd_chk("R1", 12'h088, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; dec_addr = '0;
    do_reset();
    reset_state_chk();

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) wr(VEC[i].addr, VEC[i].data);
      else @(negedge clk);
      rd_chk($sformatf("%s", VEC[i].tag), VEC[i].addr, VEC[i].exp);
    end
    chk("R6", {31'b0, remapped}, 32'h0);
    chk("R8", rom_cfg, ROM_RST);
    chk("R8", ram_cfg, RAM_RST);

    // R9 placement before remap
    dec_chk("R9", 32'h0000_0000, 1'b1, 1'b0);
    dec_chk("R9", 32'h007F_FFFC, 1'b1, 1'b0);
    dec_chk("R9", 32'h0080_0000, 1'b0, 1'b0);
    dec_chk("R9", 32'h1000_0000, 1'b0, 1'b1);
    dec_chk("R9", 32'h11FF_FFFF, 1'b0, 1'b1);
    dec_chk("R9", 32'h1200_0000, 1'b0, 1'b0);

    // R5 trigger; check both sides of the edge
    @(negedge clk);
    dec_addr = 32'h0; reg_we = 1'b1; reg_addr = 12'h088; reg_wdata = 32'h0000_0003;
    #1;
    chk("R9", {31'b0, rom_hit}, 32'h1);
    chk("R5", {31'b0, remapped}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    #1;
    chk("R5", {31'b0, remapped}, 32'h1);
    chk("R5", rom_cfg, ROM_MOVED);
    chk("R5", ram_cfg, RAM_MOVED);
    chk("R9", {31'b0, rom_hit}, 32'h0);
    chk("R9", {31'b0, ram_hit}, 32'h1);
    rd_chk("R3", 12'h010, ROM_MOVED);
    rd_chk("R3", 12'h018, RAM_MOVED);
    rd_chk("R4", 12'h088, 32'h0000_0003);

    // R9 placement after remap
    dec_chk("R9", 32'h0200_0000, 1'b1, 1'b0);
    dec_chk("R9", 32'h027F_FFFF, 1'b1, 1'b0);
    dec_chk("R9", 32'h0280_0000, 1'b0, 1'b0);
    dec_chk("R9", 32'h01FF_FFFF, 1'b0, 1'b1);

    // R7 later control writes
    wr(12'h088, 32'h0);
    rd_chk("R4", 12'h088, 32'h0);
    chk("R7", {31'b0, remapped}, 32'h1);
    wr(12'h088, 32'h0000_0001);
    chk("R7", rom_cfg, ROM_MOVED);
    chk("R7", ram_cfg, RAM_MOVED);
    chk("R7", {31'b0, remapped}, 32'h1);
    wr(12'h018, 32'hFFF0_0000);
    rd_chk("R8", 12'h018, RAM_MOVED);

    // R1 reset after remap restores boot placement
    do_reset();
    reset_state_chk();
    dec_chk("R1", 32'h0000_0000, 1'b1, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule